// File: doc/BRIEF.md
# PRBS31 Bit-Error-Rate Test Controller

This block runs a bit-error-rate test over a word-parallel loopback path. A PRBS31 generator produces one data word per clock. The word goes out on the transmit port and comes back on the receive port, through serial or parallel loopback. A checker predicts the same sequence and counts every received bit that differs from the prediction.

A small command machine starts and stops the test and reports a 2-bit status. The status shows a clean stop and an illegal command as different codes. For link margin checks, the generator can be programmed with a burst length and told to corrupt that many words, one bit each. The checker should then report exactly that many errors.

The 32-bit error total is read out as three slices of uneven width. The total saturates instead of wrapping. The checker first aligns to the incoming stream using the received bits themselves. After one clean word it switches to free-running prediction, so that each flipped bit counts once.

Top module: `prbs_ber_ctrl`

## Requirements
- R1: After reset, the status is 0 (idle) and all error slices read 0.
- R2: A start pulse while the status is not 1 sets the status to 1 (running) and clears the error total to 0.
- R3: A stop pulse while running sets the status to 3 (completed). Once the status is no longer 1, the error total stays frozen, even when the received data is corrupted.
- R4: A stop pulse while not running, or a start pulse while already running, sets the status to 2 (failure). A start while running leaves the error total unchanged. When start and stop arrive in the same cycle, start is acted on.
- R5: The transmit stream follows x^31 + x^28 + 1: each bit equals the XOR of the bits sent 31 and 28 positions earlier. Bit 0 of a word is the earliest in time, and the stream continues across words. The generator is seeded nonzero, so the stream is never all zeros.
- R6: After a start, the checker aligns on the first error-free received word. From then on, while running, it adds one to the total for every received bit that differs from the PRBS31 continuation. A clean loopback leaves the total at 0.
- R7: An inject-count load stores a 12-bit burst length. An inject pulse then flips bit 0 of exactly that many transmit words. Each corrupted word is followed by at least one clean word, so a loopback test counts exactly the burst length.
- R8: The error total is 32 bits. The total saturates at all ones instead of wrapping. It reads out as a low slice holding bits 11:0, a middle slice holding bits 27:12 and a high slice holding bits 31:28.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start-test command pulse |
| stop_i | input | 1 | Stop-test command pulse |
| inj_load_i | input | 1 | Load pulse for the burst length |
| inj_count_i | input | 12 | Burst length to load |
| inject_i | input | 1 | Begin injecting the loaded burst |
| tx_data_o | output | 32 | Generated word, bit 0 earliest |
| rx_data_i | input | 32 | Looped-back word, bit 0 earliest |
| status_o | output | 2 | 0 idle, 1 running, 2 failure, 3 completed |
| err_lo_o | output | 12 | Error total bits 11:0 |
| err_mid_o | output | 16 | Error total bits 27:12 |
| err_hi_o | output | 4 | Error total bits 31:28 |

## Verification
The assertions assume the following about the inputs:
- Commands are single-cycle pulses.
- The burst length is loaded in an earlier cycle than the inject pulse.
- After a start, the received data returns the transmitted stream cleanly for at least one word, so the checker aligns to the true sequence rather than to corrupted bits.

The bench respects these limits. It closes the loop with a purely combinational path, waits several clean cycles after each start before it corrupts data or injects errors, and drives every command as a pulse one cycle wide.

// File: rtl/ber_pkg.sv
package ber_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FAIL = 2'd2,
    ST_DONE = 2'd3
  } ber_st_e;

  localparam int unsigned PRBS_LEN  = 31;
  localparam int unsigned PRBS_TAP  = 28;
  localparam int unsigned ERR_W     = 32;
  localparam int unsigned ERR_LO_W  = 12;
  localparam int unsigned ERR_MID_W = 16;
  localparam int unsigned ERR_HI_W  = ERR_W - ERR_LO_W - ERR_MID_W;
endpackage

// File: rtl/prbs31_word.sv
module prbs31_word
  import ber_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [PRBS_LEN-1:0] hist_i,
  input  logic [DATA_W-1:0]   feed_i,
  input  logic                use_feed_i,
  output logic [DATA_W-1:0]   pred_o,
  output logic [PRBS_LEN-1:0] hist_o
);
  logic [PRBS_LEN-1:0] h;
  logic                p;

  // hist[0] is the newest bit; bit 0 of a word is the earliest in time
  always_comb begin
    h      = hist_i;
    p      = 1'b0;
    pred_o = '0;
    for (int i = 0; i < int'(DATA_W); i++) begin
      p         = h[PRBS_LEN-1] ^ h[PRBS_TAP-1];
      pred_o[i] = p;
      h         = {h[PRBS_LEN-2:0], use_feed_i ? feed_i[i] : p};
    end
    hist_o = h;
  end
endmodule

// File: rtl/prbs_gen.sv
module prbs_gen
  import ber_pkg::*;
#(
  parameter int unsigned         DATA_W = 32,
  parameter int unsigned         INJ_W  = 12,
  parameter logic [PRBS_LEN-1:0] SEED   = 31'h2AC3_1F07
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inj_load_i,
  input  logic [INJ_W-1:0]  inj_count_i,
  input  logic              inject_i,
  output logic [DATA_W-1:0] tx_data_o
);
  logic [PRBS_LEN-1:0] hist_q, hist_d;
  logic [DATA_W-1:0]   word, tx_q;
  logic [INJ_W-1:0]    prog_q, left_q;
  logic                gap_q, fire;

  prbs31_word #(.DATA_W(DATA_W)) u_word (
    .hist_i    (hist_q),
    .feed_i    ('0),
    .use_feed_i(1'b0),
    .pred_o    (word),
    .hist_o    (hist_d)
  );

  // one flip per word, never two corrupted words back to back
  assign fire = (left_q != '0) && !gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= SEED;
      prog_q <= '0;
      left_q <= '0;
      gap_q  <= 1'b0;
      tx_q   <= '0;
    end else begin
      hist_q <= hist_d;
      tx_q   <= word ^ {{(DATA_W-1){1'b0}}, fire};
      if (inj_load_i) prog_q <= inj_count_i;
      if (inject_i) begin
        left_q <= prog_q;
        gap_q  <= 1'b0;
      end else if (fire) begin
        left_q <= left_q - 1'b1;
        gap_q  <= 1'b1;
      end else begin
        gap_q  <= 1'b0;
      end
    end
  end

  assign tx_data_o = tx_q;

  // R7
  inj_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire && !inject_i |=> !fire);
  // R5
  seed_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hist_q != '0);
endmodule

// File: rtl/prbs_chk.sv
module prbs_chk
  import ber_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              run_i,
  input  logic              clr_i,
  output logic [ERR_W-1:0]  err_cnt_o
);
  localparam int unsigned NW = $clog2(DATA_W + 1);

  logic [PRBS_LEN-1:0] ref_q, ref_d;
  logic [DATA_W-1:0]   pred, mism;
  logic [NW-1:0]       nerr;
  logic [ERR_W:0]      sum;
  logic [ERR_W-1:0]    err_q, err_sat;
  logic                lock_q;

  // unlocked: follow the received bits; locked: free-run own sequence
  prbs31_word #(.DATA_W(DATA_W)) u_word (
    .hist_i    (ref_q),
    .feed_i    (rx_data_i),
    .use_feed_i(!lock_q),
    .pred_o    (pred),
    .hist_o    (ref_d)
  );

  assign mism = rx_data_i ^ pred;

  always_comb begin
    nerr = '0;
    for (int i = 0; i < int'(DATA_W); i++) nerr = nerr + NW'(mism[i]);
  end

  assign sum     = {1'b0, err_q} + (ERR_W+1)'(nerr);
  assign err_sat = sum[ERR_W] ? '1 : sum[ERR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      lock_q <= 1'b0;
      err_q  <= '0;
    end else begin
      ref_q <= ref_d;
      if (clr_i) begin
        lock_q <= 1'b0;
        err_q  <= '0;
      end else begin
        if (!lock_q && mism == '0) lock_q <= 1'b1;
        if (run_i && lock_q)       err_q  <= err_sat;
      end
    end
  end

  assign err_cnt_o = err_q;

  // R2
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> err_q == '0);
  // R8
  no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> err_q >= $past(err_q));
  // R3
  frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !clr_i |=> $stable(err_q));
endmodule

// File: rtl/ber_ctrl_fsm.sv
module ber_ctrl_fsm
  import ber_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       stop_i,
  output logic [1:0] status_o,
  output logic       run_o,
  output logic       clr_o
);
  ber_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (start_i)     st_d = (st_q == ST_RUN) ? ST_FAIL : ST_RUN;
    else if (stop_i) st_d = (st_q == ST_RUN) ? ST_DONE : ST_FAIL;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_IDLE;
    else         st_q <= st_d;
  end

  assign status_o = st_q;
  assign run_o    = (st_q == ST_RUN);
  assign clr_o    = start_i && (st_q != ST_RUN);

  // R2
  start_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && st_q != ST_RUN |=> st_q == ST_RUN);
  // R3
  stop_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i && st_q == ST_RUN |=> st_q == ST_DONE);
  // R4
  bad_cmd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_q == ST_RUN) || (stop_i && !start_i && st_q != ST_RUN)
    |=> st_q == ST_FAIL);
endmodule

// File: rtl/prbs_ber_ctrl.sv
module prbs_ber_ctrl
  import ber_pkg::*;
#(
  parameter int unsigned         DATA_W = 32,
  parameter int unsigned         INJ_W  = 12,
  parameter logic [PRBS_LEN-1:0] SEED   = 31'h2AC3_1F07
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 inj_load_i,
  input  logic [INJ_W-1:0]     inj_count_i,
  input  logic                 inject_i,
  output logic [DATA_W-1:0]    tx_data_o,
  input  logic [DATA_W-1:0]    rx_data_i,
  output logic [1:0]           status_o,
  output logic [ERR_LO_W-1:0]  err_lo_o,
  output logic [ERR_MID_W-1:0] err_mid_o,
  output logic [ERR_HI_W-1:0]  err_hi_o
);
  localparam int unsigned MID_LSB = ERR_LO_W;
  localparam int unsigned HI_LSB  = ERR_LO_W + ERR_MID_W;

  logic             run, clr;
  logic [ERR_W-1:0] err_cnt;

  ber_ctrl_fsm u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .stop_i  (stop_i),
    .status_o(status_o),
    .run_o   (run),
    .clr_o   (clr)
  );

  prbs_gen #(.DATA_W(DATA_W), .INJ_W(INJ_W), .SEED(SEED)) u_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .inj_load_i (inj_load_i),
    .inj_count_i(inj_count_i),
    .inject_i   (inject_i),
    .tx_data_o  (tx_data_o)
  );

  prbs_chk #(.DATA_W(DATA_W)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rx_data_i(rx_data_i),
    .run_i    (run),
    .clr_i    (clr),
    .err_cnt_o(err_cnt)
  );

  assign err_lo_o  = err_cnt[ERR_LO_W-1:0];
  assign err_mid_o = err_cnt[HI_LSB-1:MID_LSB];
  assign err_hi_o  = err_cnt[ERR_W-1:HI_LSB];

  // R1
  reset_idle_chk: assert property (@(posedge clk_i)
    !rst_ni |=> status_o == ST_IDLE || !rst_ni);
endmodule

// File: tb/prbs_ber_ctrl_bench.sv
module prbs_ber_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, stop = 1'b0, inj_load = 1'b0, inject = 1'b0;
  logic [11:0] inj_count = '0;
  logic [31:0] tx_data, rx_data, corrupt = '0;
  logic [1:0]  status;
  logic [11:0] err_lo;
  logic [15:0] err_mid;
  logic [3:0]  err_hi;

  int checks = 0;
  int failures = 0;

  typedef struct packed {
    logic [1:0]  st;
    logic [31:0] cnt;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  exp_t  e_cur;
  string t_cur;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign rx_data = tx_data ^ corrupt;

  prbs_ber_ctrl u_prbs_ber_ctrl (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .stop_i     (stop),
    .inj_load_i (inj_load),
    .inj_count_i(inj_count),
    .inject_i   (inject),
    .tx_data_o  (tx_data),
    .rx_data_i  (rx_data),
    .status_o   (status),
    .err_lo_o   (err_lo),
    .err_mid_o  (err_mid),
    .err_hi_o   (err_hi)
  );

  // monitor: compare queued expectations against the ports
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      e_cur = exp_q.pop_front();
      t_cur = tag_q.pop_front();
      checks++;
      if (status !== e_cur.st || {err_hi, err_mid, err_lo} !== e_cur.cnt) begin
        failures++;
        $display("FAIL %s: status=%0d cnt=%0d expected status=%0d cnt=%0d",
                 t_cur, status, {err_hi, err_mid, err_lo}, e_cur.st, e_cur.cnt);
      end
    end
  end

  task automatic expect_now(input string tag, input logic [1:0] st, input logic [31:0] cnt);
    tag_q.push_back(tag);
    exp_q.push_back('{st: st, cnt: cnt});
    while (exp_q.size() != 0) @(negedge clk);
    #1;
  endtask

  task automatic pulse(ref logic sig);
    sig = 1'b1;
    @(posedge clk);
    #1 sig = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic corrupt_for(input logic [31:0] m, input int n);
    corrupt = m;
    repeat (n) @(posedge clk);
    #1 corrupt = '0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog: cycles=%0d expected completion before %0d", WATCHDOG, WATCHDOG);
    summary();
  end

  initial begin
    logic [30:0] h;
    logic        b;
    int          bad;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    expect_now("R1", 2'd0, 32'd0);

    // R5 recurrence over the free-running stream
    @(negedge clk);
    h = tx_data[31:1];
    h = {h[0 +: 31]};
    for (int k = 0; k < 31; k++) h[k] = tx_data[31-k];
    for (int w = 0; w < 16; w++) begin
      @(negedge clk);
      bad = 0;
      for (int i = 0; i < 32; i++) begin
        b = h[30] ^ h[27];
        if (tx_data[i] !== b) bad++;
        h = {h[29:0], tx_data[i]};
      end
      checks++;
      if (bad != 0 || tx_data == '0) begin
        failures++;
        $display("FAIL R5: word %0d bad_bits=%0d data=%h expected 0 bad bits", w, bad, tx_data);
      end
    end
    #1;

    // R4 stop while idle
    pulse(stop);
    expect_now("R4", 2'd2, 32'd0);
    // R2 start
    pulse(start);
    expect_now("R2", 2'd1, 32'd0);
    idle(10);
    // R6 clean loopback counts nothing
    expect_now("R6", 2'd1, 32'd0);
    // R8 all bits wrong for 200 words: 6400
    corrupt_for('1, 200);
    expect_now("R8", 2'd1, 32'd6400);
    // R4 start while running keeps count
    pulse(start);
    expect_now("R4", 2'd2, 32'd6400);
    // R2 restart from failure clears
    pulse(start);
    expect_now("R2", 2'd1, 32'd0);
    idle(5);
    // R7 burst of 0x123
    inj_count = 12'h123;
    pulse(inj_load);
    idle(2);
    pulse(inject);
    idle(2 * 12'h123 + 20);
    expect_now("R7", 2'd1, 32'h123);
    // R6 two bits wrong per word for 7 words
    corrupt_for(32'h0000_0101, 7);
    expect_now("R6", 2'd1, 32'h123 + 32'd14);
    // R3 stop while running
    pulse(stop);
    expect_now("R3", 2'd3, 32'h123 + 32'd14);
    // R3 corruption after stop is not counted
    corrupt_for('1, 5);
    idle(2);
    expect_now("R3", 2'd3, 32'h123 + 32'd14);
    // R4 stop while completed
    pulse(stop);
    expect_now("R4", 2'd2, 32'h123 + 32'd14);
    // R4 start and stop together: start wins
    start = 1'b1;
    stop  = 1'b1;
    @(posedge clk);
    #1 begin start = 1'b0; stop = 1'b0; end
    expect_now("R4", 2'd1, 32'd0);
    idle(5);
    // R7 short burst of 3
    inj_count = 12'd3;
    pulse(inj_load);
    idle(1);
    pulse(inject);
    idle(20);
    expect_now("R7", 2'd1, 32'd3);
    summary();
  end
endmodule